// File: doc/BRIEF.md
# Synthesizer Control Word Loader

This block collects a 40-bit programming word for a direct digital synthesizer from an external controller. It holds the word in a staging register until the controller commits it. The controller drives a write clock, an update strobe and an 8-bit data bus. All three are asynchronous to the system clock, so the block synchronizes them and acts on their rising edges.

There are two loading modes, and both fill the same staging register. In byte mode, each write-clock edge stores one bus byte at the position of a byte pointer and then advances the pointer. After five bytes the pointer stops and further write clocks have no effect. In bit mode, each write-clock edge shifts in a single bit taken from bus bit 7.

A rising edge on the update strobe copies the staged word into the active register and returns the pointer to the first byte. The active register drives the synthesizer core with:
- a 32-bit tuning word,
- a 5-bit phase word,
- a power-down flag,
- a 2-bit control field.

Top module: `dds_word_loader`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the byte pointer, the staging word and the active word, so every output reads zero.
- R2: In byte mode (serial_mode=0), the first byte lands in the control byte: bits 7:3 become the phase word, bit 2 the power-down flag and bits 1:0 the control field. The next four bytes form the tuning word, most significant byte first.
- R3: After five byte-mode writes, further write-clock edges leave the staging word unchanged until an update strobe or a reset.
- R4: Outputs change only on a detected update-strobe rising edge. At that edge the active word takes the value the staging word had just before it.
- R5: An update-strobe rising edge returns the byte pointer to the first byte, even after a partial load. The next byte-mode write therefore lands in the control byte.
- R6: In bit mode (serial_mode=1), each write-clock rising edge shifts data_in[7] into the word, least significant first. After 40 edges, the first bit sent is tuning bit 0 and the last bit sent is phase bit 4.
- R7: A word shifted in bit mode reaches the outputs only after an update strobe follows it.
- R8: An input held high acts once per rising edge, however long it stays high.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_clk_in | input | 1 | Asynchronous write clock from the controller |
| upd_in | input | 1 | Asynchronous update strobe |
| serial_mode | input | 1 | 1 selects bit mode, 0 selects byte mode |
| data_in | input | 8 | Data bus; bit mode uses bit 7 only |
| tune_word | output | 32 | Active frequency tuning word |
| phase_word | output | 5 | Active phase word |
| pwr_down | output | 1 | Active power-down flag |
| ctrl_field | output | 2 | Active control field |

## Verification
The assertions check on every cycle that:
- the pointer stays in range and holds once it is full,
- the staging word is frozen while the pointer is saturated in byte mode,
- the active word moves only right after an update edge, and then takes the prior staged value,
- edge pulses last one cycle.

The field placement of byte and bit loads, the restart of the pointer after a partial load, and a long-held write clock counting as one shift can only be shown by the bench scenarios. These scenarios compare the decoded outputs against words built from the requirement layout.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;

    localparam int WORD_W  = 40;
    localparam int BYTE_W  = 8;
    localparam int TUNE_W  = 32;
    localparam int PHASE_W = 5;
    localparam int CTRL_W  = 2;
    localparam int N_BYTES = WORD_W / BYTE_W;
    localparam int PTR_W   = $clog2(N_BYTES + 1);
    localparam int SER_BIT = BYTE_W - 1;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pd;
        logic [CTRL_W-1:0]  ctrl;
        logic [TUNE_W-1:0]  tune;
    } dds_word_t;

    typedef enum logic { LOAD_BYTE = 1'b0, LOAD_BIT = 1'b1 } load_mode_t;

    function automatic int lane_msb(input int lane);
        return WORD_W - 1 - lane * BYTE_W;
    endfunction

endpackage

// File: rtl/dds_sync_edge.sv
module dds_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dds_byte_ptr.sv
module dds_byte_ptr
    import dds_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr,
    output logic             full
);
    logic [PTR_W-1:0] ptr_q;

    assign full = (ptr_q == PTR_W'(N_BYTES));
    assign ptr  = ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr_q <= '0;
        else if (adv && !full)
            ptr_q <= ptr_q + 1'b1;
    end
endmodule

// File: rtl/dds_stage_reg.sv
module dds_stage_reg
    import dds_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  load_mode_t        mode,
    input  logic              wr,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              full,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] stage
);
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] par_next;
    logic [WORD_W-1:0] ser_next;
    logic [WORD_W-1:0] stage_d;

    generate
        for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
            localparam int MSB = lane_msb(g);
            always_comb begin
                if (ptr == PTR_W'(g))
                    par_next[MSB -: BYTE_W] = din;
                else
                    par_next[MSB -: BYTE_W] = stage_q[MSB -: BYTE_W];
            end
        end
    endgenerate

    assign ser_next = {din[SER_BIT], stage_q[WORD_W-1:1]};

    always_comb begin
        stage_d = stage_q;
        if (wr) begin
            if (mode == LOAD_BIT)
                stage_d = ser_next;
            else if (!full)
                stage_d = par_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign stage = stage_q;
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dds_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_clk_in,
    input  logic              upd_in,
    input  logic              serial_mode,
    input  logic [BYTE_W-1:0] data_in,
    output logic [TUNE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic              pwr_down,
    output logic [CTRL_W-1:0] ctrl_field
);
    logic              wr_pulse;
    logic              upd_pulse;
    logic [PTR_W-1:0]  ptr_q;
    logic              ptr_full;
    logic [WORD_W-1:0] stage_w;
    dds_word_t         active_q;
    load_mode_t        mode;

    assign mode = serial_mode ? LOAD_BIT : LOAD_BYTE;

    dds_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk (clk), .rst (rst), .din (wr_clk_in), .rise (wr_pulse)
    );

    dds_sync_edge #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk (clk), .rst (rst), .din (upd_in), .rise (upd_pulse)
    );

    dds_byte_ptr u_ptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (wr_pulse && (mode == LOAD_BYTE)),
        .clr  (upd_pulse),
        .ptr  (ptr_q),
        .full (ptr_full)
    );

    dds_stage_reg u_stage (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .wr    (wr_pulse),
        .ptr   (ptr_q),
        .full  (ptr_full),
        .din   (data_in),
        .stage (stage_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (upd_pulse)
            active_q <= dds_word_t'(stage_w);
    end

    assign tune_word  = active_q.tune;
    assign phase_word = active_q.phase;
    assign pwr_down   = active_q.pd;
    assign ctrl_field = active_q.ctrl;
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk
    import dds_loader_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              serial_mode,
    input logic              wr_pulse,
    input logic              upd_pulse,
    input logic [PTR_W-1:0]  ptr,
    input logic [WORD_W-1:0] stage,
    input logic [WORD_W-1:0] active
);
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(N_BYTES)); // R3

    AST_PTR_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ptr) == PTR_W'(N_BYTES) && !$past(upd_pulse))
            |-> ptr == PTR_W'(N_BYTES)); // R3

    AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ptr) == PTR_W'(N_BYTES) && !$past(serial_mode))
            |-> $stable(stage)); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_pulse)) |-> $stable(active)); // R4

    AST_OUT_XFER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_pulse)) |-> active == $past(stage)); // R4

    AST_PTR_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_pulse)) |-> ptr == '0); // R5

    AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse); // R8

    AST_UPD_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse); // R8
endmodule

bind dds_word_loader dds_word_loader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .serial_mode (serial_mode),
    .wr_pulse    (wr_pulse),
    .upd_pulse   (upd_pulse),
    .ptr         (ptr_q),
    .stage       (stage_w),
    .active      (active_q)
);

// File: tb/sim_dds_word_loader.sv
`timescale 1ns/1ps
module sim_dds_word_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_clk_in = 1'b0;
    logic        upd_in = 1'b0;
    logic        serial_mode = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [31:0] tune_word;
    logic [4:0]  phase_word;
    logic        pwr_down;
    logic [1:0]  ctrl_field;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dds_word_loader u0 (
        .clk(clk), .rst(rst), .wr_clk_in(wr_clk_in), .upd_in(upd_in),
        .serial_mode(serial_mode), .data_in(data_in), .tune_word(tune_word),
        .phase_word(phase_word), .pwr_down(pwr_down), .ctrl_field(ctrl_field)
    );

    localparam logic [39:0] PVEC [0:3] = '{
        40'hA5_12345678, 40'h3C_DEADBEEF, 40'hFF_00000001, 40'h00_FFFFFFFF
    };

    // Output word in requirement layout: phase[39:35], pd[34], ctrl[33:32], tune[31:0]
    function automatic logic [39:0] out_word();
        return {phase_word, pwr_down, ctrl_field, tune_word};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [39:0] exp);
        @(negedge clk);
        check(out_word() === exp, tag, out_word(), exp);
    endtask

    task automatic wr_edge(input logic [7:0] d, input int hold);
        @(negedge clk);
        data_in = d;
        wr_clk_in = 1'b1;
        repeat (hold) @(negedge clk);
        wr_clk_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic upd_edge();
        @(negedge clk);
        upd_in = 1'b1;
        repeat (5) @(negedge clk);
        upd_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic load_bytes(input logic [39:0] w);
        for (int k = 0; k < 5; k++) wr_edge(w[39 - 8*k -: 8], 5);
    endtask

    task automatic shift_bit(input logic b, input int hold);
        wr_edge(b ? 8'h80 : 8'h7F, hold);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [39:0] w;
        logic [39:0] s;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_out("R1 reset outputs", 40'h0);

        // Table walk: byte-mode loads
        for (int i = 0; i < 4; i++) begin
            load_bytes(PVEC[i]);
            // R4: no change before strobe
            check_out("R4 hold before update", (i == 0) ? 40'h0 : PVEC[i-1]);
            upd_edge();
            check_out("R2 byte layout", PVEC[i]);
        end

        // R3: extra writes after five are ignored
        w = 40'h5A_CAFEF00D;
        load_bytes(w);
        wr_edge(8'hFF, 5);
        wr_edge(8'h11, 5);
        upd_edge();
        check_out("R3 saturated pointer", w);

        // R5: partial load then update restarts pointer
        wr_edge(8'hC3, 5);
        wr_edge(8'h99, 5);
        upd_edge();
        check_out("R5 partial load", {8'hC3, 8'h99, w[23:0]});
        wr_edge(8'h4E, 5);
        upd_edge();
        check_out("R5 pointer restart", {8'h4E, 8'h99, w[23:0]});

        // R6/R7: bit mode, LSB first
        serial_mode = 1'b1;
        s = 40'h9B_13579BDF;
        for (int k = 0; k < 40; k++) shift_bit(s[k], 3);
        check_out("R7 bit mode needs update", {8'h4E, 8'h99, w[23:0]});
        upd_edge();
        check_out("R6 bit order", s);

        // R8: long-held write clock shifts once
        shift_bit(1'b1, 40);
        upd_edge();
        check_out("R8 single shift on held input", {1'b1, s[39:1]});

        // R1: reset mid-run, then pointer starts at byte 0
        serial_mode = 1'b0;
        wr_edge(8'h77, 5);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_out("R1 reset clears active", 40'h0);
        wr_edge(8'hE1, 5);
        upd_edge();
        check_out("R1 reset clears pointer and stage", {8'hE1, 32'h0});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule